// File: doc/BRIEF.md
# Bit-Field and Byte Manipulation Unit

This unit is the non-arithmetic bit-operation slice of a 32-bit integer execution pipeline. It takes two source operands (a source value and a target value), two 5-bit immediate fields (a position and a size), a 5-bit sub-selector and an operation code. From these it computes one of the following:

- field extract and field insert;
- a byte swap within each halfword, or a byte swap across the whole word;
- full bit reversal;
- byte or halfword sign extension;
- a count of leading zeros or leading ones;
- a rotate right by an immediate or by a register amount;
- a signed maximum or minimum.

The result is registered and appears one cycle after a valid request. It carries a valid flag, the destination index, an illegal flag and a write-enable for the register file. The write-enable drops when the destination is register 0 or when the request is illegal.

The unit has no register file, adder or plain shifter. The surrounding pipeline reads the operands and consumes the registered result.

Top module: `bitfield_unit`

## Requirements
- R1: Op 0 (extract) returns (a_val >> pos_f) masked to its low size_f+1 bits. All higher result bits are zero.
- R2: Op 1 (insert) replaces bits pos_f through size_f of b_val with the low bits of a_val and keeps every other bit of b_val. When size_f < pos_f the request is illegal.
- R3: Op 2 (halfword swap) exchanges the two bytes inside each 16-bit half of b_val.
- R4: Op 3 (word swap) reverses the order of the four bytes of b_val. Op 4 (bit reverse) moves bit i of b_val to bit 31-i.
- R5: Op 5 sign-extends b_val[7:0] to 32 bits. Op 6 sign-extends b_val[15:0] to 32 bits.
- R6: Op 7 returns the number of leading zeros of a_val, which is 32 for zero. Op 8 returns the number of leading ones of a_val, which is 32 for all ones.
- R7: Op 9 rotates b_val right by pos_f, and op 10 rotates b_val right by a_val[4:0]. Both are legal only when sub_sel equals 1; any other sub_sel makes the request illegal.
- R8: Op 11 returns whichever of a_val and b_val is larger as a signed 32-bit value. Op 12 returns the signed smaller one.
- R9: Op codes 13, 14 and 15 are illegal. An illegal request sets res_illegal, returns res_data 0 and keeps res_we low.
- R10: A legal result addressed to dest_idx 0 is still returned with res_valid, but res_we stays low.
- R11: Each valid request produces exactly one res_valid pulse in the next cycle, carrying its dest_idx. In a cycle without a request, res_valid, res_we and res_illegal are 0.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Operation select (see requirements) |
| a_val | input | 32 | Source operand |
| b_val | input | 32 | Target operand (old value for insert) |
| pos_f | input | 5 | Position / immediate rotate amount |
| size_f | input | 5 | Most-significant field bit index |
| sub_sel | input | 5 | Variant selector for rotates |
| dest_idx | input | 5 | Destination register index |
| res_valid | output | 1 | Result present |
| res_data | output | 32 | Result value |
| res_we | output | 1 | Register write-enable |
| res_dest | output | 5 | Destination index of the result |
| res_illegal | output | 1 | Request was illegal |

## Verification
The bench checks several boundaries:

- An extract with a full 32-bit field, where a width computation off by one would lose or duplicate the top bit.
- An insert at the top of the word.
- An insert whose size lies below its position, which a careless design would turn into a huge mask.
- Count-leading on zero and on all-ones, where a priority search without a default returns 31 or garbage.
- Rotate by 0 and by 31, where a shift-and-or rotate breaks at 0.
- Max and min with operands of opposite sign, which an unsigned compare gets backwards.

Rotates with a wrong sub-selector, reserved op codes and destination 0 must each leave the write-enable low while still producing a valid pulse.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] b_val,
  input  logic [4:0]   pos_f,
  input  logic [4:0]   size_f,
  input  logic [4:0]   sub_sel,
  input  logic [4:0]   dest_idx,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_we,
  output logic [4:0]   res_dest,
  output logic         res_illegal
);
  localparam int CW = $clog2(W) + 1;

  localparam logic [3:0] OP_EXT  = 4'd0;
  localparam logic [3:0] OP_INS  = 4'd1;
  localparam logic [3:0] OP_HSWP = 4'd2;
  localparam logic [3:0] OP_WSWP = 4'd3;
  localparam logic [3:0] OP_BREV = 4'd4;
  localparam logic [3:0] OP_SXB  = 4'd5;
  localparam logic [3:0] OP_SXH  = 4'd6;
  localparam logic [3:0] OP_CLZ  = 4'd7;
  localparam logic [3:0] OP_CLO  = 4'd8;
  localparam logic [3:0] OP_RORI = 4'd9;
  localparam logic [3:0] OP_RORV = 4'd10;
  localparam logic [3:0] OP_MAX  = 4'd11;
  localparam logic [3:0] OP_MIN  = 4'd12;

  function automatic logic [CW-1:0] lead_zeros(input logic [W-1:0] v);
    lead_zeros = CW'(W);
    for (int i = 0; i < W; i++)
      if (v[i]) lead_zeros = CW'(W - 1 - i);
  endfunction

  function automatic logic [W-1:0] ror(input logic [W-1:0] v, input logic [4:0] n);
    ror = (n == 5'd0) ? v : ((v >> n) | (v << (6'd32 - {1'b0, n})));
  endfunction

  logic [W-1:0] up_mask, lo_mask, ins_mask, rev_b, nxt_data;
  logic         nxt_bad;

  assign up_mask  = ~({W{1'b1}} << 1 << size_f);
  assign lo_mask  = ~({W{1'b1}} << pos_f);
  assign ins_mask = up_mask & ~lo_mask;

  always_comb
    for (int i = 0; i < W; i++) rev_b[i] = b_val[W-1-i];

  always_comb begin
    nxt_data = '0;
    nxt_bad  = 1'b0;
    unique case (op_code)
      OP_EXT:  nxt_data = (a_val >> pos_f) & up_mask;
      OP_INS: begin
        nxt_bad  = size_f < pos_f;
        nxt_data = (b_val & ~ins_mask) | ((a_val << pos_f) & ins_mask);
      end
      OP_HSWP: nxt_data = {b_val[23:16], b_val[31:24], b_val[7:0], b_val[15:8]};
      OP_WSWP: nxt_data = {b_val[7:0], b_val[15:8], b_val[23:16], b_val[31:24]};
      OP_BREV: nxt_data = rev_b;
      OP_SXB:  nxt_data = {{(W-8){b_val[7]}}, b_val[7:0]};
      OP_SXH:  nxt_data = {{(W-16){b_val[15]}}, b_val[15:0]};
      OP_CLZ:  nxt_data = W'(lead_zeros(a_val));
      OP_CLO:  nxt_data = W'(lead_zeros(~a_val));
      OP_RORI: begin
        nxt_bad  = sub_sel != 5'd1;
        nxt_data = ror(b_val, pos_f);
      end
      OP_RORV: begin
        nxt_bad  = sub_sel != 5'd1;
        nxt_data = ror(b_val, a_val[4:0]);
      end
      OP_MAX:  nxt_data = ($signed(a_val) > $signed(b_val)) ? a_val : b_val;
      OP_MIN:  nxt_data = ($signed(a_val) < $signed(b_val)) ? a_val : b_val;
      default: nxt_bad  = 1'b1;
    endcase
    if (nxt_bad) nxt_data = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_we      <= 1'b0;
      res_dest    <= '0;
      res_illegal <= 1'b0;
    end else begin
      res_valid   <= in_valid;
      res_illegal <= in_valid & nxt_bad;
      res_we      <= in_valid & ~nxt_bad & (dest_idx != 5'd0);
      if (in_valid) begin
        res_data <= nxt_data;
        res_dest <= dest_idx;
      end
    end
  end

  // R10
  we_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_valid && res_dest != 5'd0));

  // R9
  illegal_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (!res_we && res_data == '0));

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_valid && res_dest == $past(dest_idx)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && !res_we && !res_illegal));

  // R4
  wswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == OP_WSWP) |=>
      (res_data[7:0] == $past(b_val[31:24]) && res_data[31:24] == $past(b_val[7:0])));

  // R8
  max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == OP_MAX) |=>
      (!($signed(res_data) < $signed($past(a_val))) && !($signed(res_data) < $signed($past(b_val)))));
endmodule

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] a_val = '0, b_val = '0;
  logic [4:0]  pos_f = '0, size_f = '0, sub_sel = '0, dest_idx = '0;
  logic        res_valid, res_we, res_illegal;
  logic [31:0] res_data;
  logic [4:0]  res_dest;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bitfield_unit uut (.clk, .rst_n, .in_valid, .op_code, .a_val, .b_val, .pos_f,
    .size_f, .sub_sel, .dest_idx, .res_valid, .res_data, .res_we, .res_dest, .res_illegal);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] p, input logic [4:0] s, input logic [4:0] sub,
                       input logic [4:0] d);
    @(negedge clk);
    op_code = op; a_val = a; b_val = b; pos_f = p; size_f = s; sub_sel = sub; dest_idx = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] exp, input logic [4:0] d);
    check({tag, " valid"}, 32'(res_valid), 32'd1);
    check({tag, " data"}, res_data, exp);
    check({tag, " illegal"}, 32'(res_illegal), 32'd0);
    check({tag, " we"}, 32'(res_we), 32'(d != 0));
  endtask

  task automatic expect_bad(input string tag);
    check({tag, " valid"}, 32'(res_valid), 32'd1);
    check({tag, " illegal"}, 32'(res_illegal), 32'd1);
    check({tag, " we"}, 32'(res_we), 32'd0);
    check({tag, " data"}, res_data, 32'd0);
  endtask

  function automatic logic [31:0] m_ext(logic [31:0] a, int p, int s);
    m_ext = '0;
    for (int i = 0; i <= s; i++) if (p + i < 32) m_ext[i] = a[p + i];
  endfunction
  function automatic logic [31:0] m_ins(logic [31:0] a, logic [31:0] b, int p, int s);
    m_ins = b;
    for (int i = p; i <= s; i++) m_ins[i] = a[i - p];
  endfunction
  function automatic logic [31:0] m_rev(logic [31:0] b);
    for (int i = 0; i < 32; i++) m_rev[31 - i] = b[i];
  endfunction
  function automatic logic [31:0] m_lead(logic [31:0] a, logic bitv);
    m_lead = 0;
    for (int i = 31; i >= 0; i--) begin
      if (a[i] != bitv) break;
      m_lead++;
    end
  endfunction
  function automatic logic [31:0] m_rot(logic [31:0] b, int n);
    for (int i = 0; i < 32; i++) m_rot[i] = b[(i + n) % 32];
  endfunction

  task automatic t_reset;
    check("R12 reset valid", 32'(res_valid), 0);
    check("R12 reset data", res_data, 0);
    check("R12 reset we", 32'(res_we), 0);
    check("R12 reset illegal", 32'(res_illegal), 0);
  endtask

  task automatic t_extract;
    issue(4'd0, 32'hDEADBEEF, 0, 5'd4, 5'd7, 0, 5'd3);
    expect_ok("R1 ext mid", m_ext(32'hDEADBEEF, 4, 7), 5'd3);
    issue(4'd0, 32'hDEADBEEF, 0, 5'd0, 5'd31, 0, 5'd3);
    expect_ok("R1 ext full", 32'hDEADBEEF, 5'd3);
    issue(4'd0, 32'h8000_0001, 0, 5'd31, 5'd4, 0, 5'd3);
    expect_ok("R1 ext top", m_ext(32'h8000_0001, 31, 4), 5'd3);
  endtask

  task automatic t_insert;
    issue(4'd1, 32'h0000_0005, 32'hFFFF_FFFF, 5'd8, 5'd11, 0, 5'd4);
    expect_ok("R2 ins mid", m_ins(32'h5, 32'hFFFF_FFFF, 8, 11), 5'd4);
    issue(4'd1, 32'h0000_00A5, 32'h1234_5678, 5'd24, 5'd31, 0, 5'd4);
    expect_ok("R2 ins top", m_ins(32'hA5, 32'h1234_5678, 24, 31), 5'd4);
    issue(4'd1, 32'hFFFF_FFFF, 32'h1234_5678, 5'd9, 5'd3, 0, 5'd4);
    expect_bad("R2 ins size<pos");
  endtask

  task automatic t_swaps;
    issue(4'd2, 0, 32'h1122_3344, 0, 0, 0, 5'd5);
    expect_ok("R3 hswap", 32'h2211_4433, 5'd5);
    issue(4'd3, 0, 32'h1122_3344, 0, 0, 0, 5'd5);
    expect_ok("R4 wswap", 32'h4433_2211, 5'd5);
    issue(4'd4, 0, 32'h0000_0001, 0, 0, 0, 5'd5);
    expect_ok("R4 brev one", 32'h8000_0000, 5'd5);
    issue(4'd4, 0, 32'hF0C3_1235, 0, 0, 0, 5'd5);
    expect_ok("R4 brev mix", m_rev(32'hF0C3_1235), 5'd5);
  endtask

  task automatic t_sext;
    issue(4'd5, 0, 32'h1234_5680, 0, 0, 0, 5'd6);
    expect_ok("R5 sxb neg", 32'hFFFF_FF80, 5'd6);
    issue(4'd5, 0, 32'hFFFF_FF7F, 0, 0, 0, 5'd6);
    expect_ok("R5 sxb pos", 32'h0000_007F, 5'd6);
    issue(4'd6, 0, 32'h0000_8001, 0, 0, 0, 5'd6);
    expect_ok("R5 sxh neg", 32'hFFFF_8001, 5'd6);
  endtask

  task automatic t_count;
    issue(4'd7, 32'h0, 0, 0, 0, 0, 5'd7);
    expect_ok("R6 clz zero", 32'd32, 5'd7);
    issue(4'd7, 32'h0001_0000, 0, 0, 0, 0, 5'd7);
    expect_ok("R6 clz mid", m_lead(32'h0001_0000, 1'b0), 5'd7);
    issue(4'd8, 32'hFFFF_FFFF, 0, 0, 0, 0, 5'd7);
    expect_ok("R6 clo ones", 32'd32, 5'd7);
    issue(4'd8, 32'hFF80_0000, 0, 0, 0, 0, 5'd7);
    expect_ok("R6 clo mid", m_lead(32'hFF80_0000, 1'b1), 5'd7);
  endtask

  task automatic t_rotate;
    issue(4'd9, 0, 32'h8765_4321, 5'd8, 0, 5'd1, 5'd8);
    expect_ok("R7 rori 8", m_rot(32'h8765_4321, 8), 5'd8);
    issue(4'd9, 0, 32'h8765_4321, 5'd0, 0, 5'd1, 5'd8);
    expect_ok("R7 rori 0", 32'h8765_4321, 5'd8);
    issue(4'd10, 32'hFFFF_FFFF, 32'h8765_4321, 0, 0, 5'd1, 5'd8);
    expect_ok("R7 rorv 31", m_rot(32'h8765_4321, 31), 5'd8);
    issue(4'd9, 0, 32'h8765_4321, 5'd4, 0, 5'd0, 5'd8);
    expect_bad("R7 rori sub0");
    issue(4'd10, 32'd3, 32'h8765_4321, 0, 0, 5'd2, 5'd8);
    expect_bad("R7 rorv sub2");
  endtask

  task automatic t_minmax;
    issue(4'd11, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 5'd9);
    expect_ok("R8 max signs", 32'h0000_0001, 5'd9);
    issue(4'd12, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 5'd9);
    expect_ok("R8 min signs", 32'hFFFF_FFFF, 5'd9);
    issue(4'd11, 32'h8000_0000, 32'h8000_0005, 0, 0, 0, 5'd9);
    expect_ok("R8 max neg", 32'h8000_0005, 5'd9);
  endtask

  task automatic t_illegal;
    for (int k = 13; k < 16; k++) begin
      issue(4'(k), 32'hABCD_EF01, 32'h1357_9BDF, 0, 0, 5'd1, 5'd10);
      expect_bad("R9 reserved op");
    end
  endtask

  task automatic t_zero_dest;
    issue(4'd3, 0, 32'hAABB_CCDD, 0, 0, 0, 5'd0);
    expect_ok("R10 dest0", 32'hDDCC_BBAA, 5'd0);
    check("R10 dest0 idx", 32'(res_dest), 0);
  endtask

  task automatic t_timing;
    issue(4'd2, 0, 32'h0102_0304, 0, 0, 0, 5'd17);
    check("R11 dest carried", 32'(res_dest), 32'd17);
    @(negedge clk);
    check("R11 single pulse", 32'(res_valid), 0);
    check("R11 idle we", 32'(res_we), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_extract(); t_insert(); t_swaps(); t_sext(); t_count();
    t_rotate(); t_minmax(); t_illegal(); t_zero_dest(); t_timing();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule